// File: doc/BRIEF.md
# Gain Dwell Timer for Automatic Gain Control

This block chooses the gain state of a receiver's low-noise amplifier from a one-bit comparator flag that says whether received power currently lies above the gain-switching threshold. When power rises above the threshold, the amplifier is put into low gain in that same cycle. Gain goes back to high only after power has stayed below the threshold for a programmable dwell time. The hysteresis therefore acts in one direction only. Its purpose is to stop amplitude-keyed data, whose high symbols sit above the threshold and whose low symbols sit below it, from flipping the gain on every bit.

The dwell length is a power of two, counted in crystal clock cycles. The exponent is held in an 8-bit register inside the block, and a write strobe loads it. Exponents larger than the counter can reach are clamped to the longest dwell the counter supports. The threshold comparator itself is outside this block.

Top module: `agc_dwell_timer`

## Requirements
- R1: `lowGain` is 1 in every cycle in which `aboveThr` is 1, including the first such cycle, with no clock delay.
- R2: When `aboveThr` goes low, `lowGain` stays 1 for exactly 2^E clock cycles, counted from and including the first cycle with `aboveThr` low, and then goes to 0. E is the effective exponent. An exponent of 0 gives one cycle.
- R3: If `aboveThr` returns to 1 during a dwell, the dwell restarts. After the next drop, the full 2^E cycles are counted again.
- R4: A clock edge with `dwellWe` at 1 loads `dwellWdata` into the exponent register. Every dwell that starts afterwards uses the new value.
- R5: While `lowGain` is 0 and `aboveThr` stays 0, `lowGain` stays 0.
- R6: An exponent above `MAX_EXP` acts as `MAX_EXP`, so the dwell is 2^MAX_EXP cycles. No dwell ever exceeds that length.
- R7: After reset the block is in high gain, so `lowGain` is 0 while `aboveThr` is 0. The exponent register holds 0x0D, which gives a dwell of 8192 cycles when `MAX_EXP` is at least 13.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Crystal clock |
| rstN | input | 1 | Asynchronous reset, active low |
| aboveThr | input | 1 | Received power is above the gain-switching threshold |
| dwellWe | input | 1 | Write strobe for the dwell exponent register |
| dwellWdata | input | 8 | New dwell exponent |
| lowGain | output | 1 | 1 = amplifier in low gain, 0 = high gain |

## Verification
The bench builds the block with `MAX_EXP` = 14. The reset exponent of 13 then still falls inside the counter's range, so the 8192-cycle default dwell can be measured directly. A saturated dwell of 16384 cycles also stays short enough to measure for exponents 14, 15 and 200. Short exponents from 0 to 5 are used to check the exact cycle count at the boundaries, the restart when the flag returns mid-dwell, and that a register write takes effect.

// File: rtl/agc_dwell_pkg.sv
package agc_dwell_pkg;

  typedef enum logic {
    GAIN_HIGH = 1'b0,
    GAIN_LOW  = 1'b1
  } gainState_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic clear;  // restart the dwell count
    logic step;   // advance the dwell count by one
  } dwellStrobes_t;

endpackage

// File: rtl/agc_dwell_datapath.sv
module agc_dwell_datapath
  import agc_dwell_pkg::*;
#(
  parameter int          EXP_W     = 8,
  parameter int          MAX_EXP   = 20,
  parameter logic [7:0]  RESET_EXP = 8'h0D
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             dwellWe,
  input  logic [EXP_W-1:0] dwellWdata,
  input  dwellStrobes_t    strobes,
  output logic             dwellDone
);

  localparam int CNT_W = MAX_EXP + 1;
  localparam int EFF_W = $clog2(MAX_EXP + 1);

  logic [EXP_W-1:0] dwellReg;
  logic [EFF_W-1:0] effExp;
  logic [CNT_W-1:0] target;
  logic [CNT_W-1:0] cnt;

  // Exponent register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dwellReg <= EXP_W'(RESET_EXP);
    end else if (dwellWe) begin
      dwellReg <= dwellWdata;
    end
  end

  // Clamp the exponent to what the counter can hold
  always_comb begin
    if (dwellReg > EXP_W'(MAX_EXP)) begin
      effExp = EFF_W'(MAX_EXP);
    end else begin
      effExp = dwellReg[EFF_W-1:0];
    end
    target = CNT_W'(1) << effExp;
  end

  // Dwell counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt <= '0;
    end else if (strobes.clear) begin
      cnt <= '0;
    end else if (strobes.step) begin
      cnt <= cnt + CNT_W'(1);
    end
  end

  // >= also covers the case where the exponent shrinks mid-dwell
  assign dwellDone = (cnt >= (target - CNT_W'(1)));

endmodule

// File: rtl/agc_dwell_ctrl.sv
module agc_dwell_ctrl
  import agc_dwell_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic          aboveThr,
  input  logic          dwellDone,
  output dwellStrobes_t strobes,
  output logic          lowGainState
);

  gainState_t state;
  gainState_t stateNext;

  always_comb begin
    stateNext     = state;
    strobes       = '0;
    if (aboveThr) begin
      stateNext     = GAIN_LOW;
      strobes.clear = 1'b1;
    end else if (state == GAIN_LOW) begin
      if (dwellDone) begin
        stateNext     = GAIN_HIGH;
        strobes.clear = 1'b1;
      end else begin
        strobes.step = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= GAIN_HIGH;
    end else begin
      state <= stateNext;
    end
  end

  assign lowGainState = (state == GAIN_LOW);

endmodule

// File: rtl/agc_dwell_timer.sv
module agc_dwell_timer
  import agc_dwell_pkg::*;
#(
  parameter int         MAX_EXP   = 20,
  parameter logic [7:0] RESET_EXP = 8'h0D
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       aboveThr,
  input  logic       dwellWe,
  input  logic [7:0] dwellWdata,
  output logic       lowGain
);

  dwellStrobes_t strobes;
  logic          dwellDone;
  logic          lowGainState;

  agc_dwell_ctrl ctrl_i (
    .clk          (clk),
    .rstN         (rstN),
    .aboveThr     (aboveThr),
    .dwellDone    (dwellDone),
    .strobes      (strobes),
    .lowGainState (lowGainState)
  );

  agc_dwell_datapath #(
    .EXP_W     (8),
    .MAX_EXP   (MAX_EXP),
    .RESET_EXP (RESET_EXP)
  ) dp_i (
    .clk        (clk),
    .rstN       (rstN),
    .dwellWe    (dwellWe),
    .dwellWdata (dwellWdata),
    .strobes    (strobes),
    .dwellDone  (dwellDone)
  );

  // Low gain takes effect in the same cycle the flag rises
  assign lowGain = aboveThr | lowGainState;

endmodule

// File: rtl/agc_dwell_checker.sv
module agc_dwell_checker #(
  parameter int MAX_EXP = 20
) (
  input logic clk,
  input logic rstN,
  input logic aboveThr,
  input logic lowGain
);

  localparam int RUN_W = MAX_EXP + 2;
  localparam logic [RUN_W-1:0] RUN_LIMIT = RUN_W'(1) << MAX_EXP;

  logic [RUN_W-1:0] belowRun;

  // Length of the current low-gain stretch spent below the threshold
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      belowRun <= '0;
    end else if (aboveThr || !lowGain) begin
      belowRun <= '0;
    end else if (belowRun <= RUN_LIMIT) begin
      belowRun <= belowRun + RUN_W'(1);
    end
  end

  AST_ENTER_LOW: assert property (@(posedge clk) disable iff (!rstN)
    aboveThr |-> lowGain);  // R1

  AST_HOLD_AFTER_DROP: assert property (@(posedge clk) disable iff (!rstN)
    $past(aboveThr) |-> lowGain);  // R2

  AST_STAY_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    !lowGain |=> (lowGain == aboveThr));  // R5

  AST_MAX_DWELL: assert property (@(posedge clk) disable iff (!rstN)
    belowRun <= RUN_LIMIT);  // R6

  always_ff @(posedge clk) begin
    if (!rstN && !aboveThr) begin
      AST_RESET_HIGH: assert (!lowGain);  // R7
    end
  end

endmodule

bind agc_dwell_timer agc_dwell_checker #(.MAX_EXP(MAX_EXP)) chk_i (
  .clk      (clk),
  .rstN     (rstN),
  .aboveThr (aboveThr),
  .lowGain  (lowGain)
);

// File: tb/agc_dwell_timer_tb_top.sv
module agc_dwell_timer_tb_top;

  localparam int MAX_EXP  = 14;
  localparam int WD_LIMIT = 190000;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       aboveThr = 1'b0;
  logic       dwellWe = 1'b0;
  logic [7:0] dwellWdata = 8'h00;
  logic       lowGain;

  int compared = 0;
  int mismatched = 0;
  bit summaryDone = 1'b0;

  always #5 clk = ~clk;

  agc_dwell_timer #(.MAX_EXP(MAX_EXP)) dut_i (
    .clk        (clk),
    .rstN       (rstN),
    .aboveThr   (aboveThr),
    .dwellWe    (dwellWe),
    .dwellWdata (dwellWdata),
    .lowGain    (lowGain)
  );

  task automatic check(input string req, input int actual, input int expected);
    compared++;
    if (actual != expected) begin
      mismatched++;
      $display("FAIL %s: actual %0d expected %0d", req, actual, expected);
    end
  endtask

  task automatic finishRun();
    if (!summaryDone) begin
      summaryDone = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  endtask

  task automatic writeExp(input logic [7:0] v);
    @(posedge clk); #1;
    dwellWe = 1'b1;
    dwellWdata = v;
    @(posedge clk); #1;
    dwellWe = 1'b0;
  endtask

  // Raise the flag for a few cycles, drop it, and count low-gain cycles
  task automatic measureDwell(output int n);
    @(posedge clk); #1;
    aboveThr = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    aboveThr = 1'b0;
    n = 0;
    for (int i = 0; i < 40000; i++) begin
      @(negedge clk);
      if (lowGain) n++;
      else break;
    end
  endtask

  task automatic testReset();
    @(negedge clk);
    check("R7 low gain during reset", int'(lowGain), 0);
    @(posedge clk); #1;
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    check("R7 high gain after reset", int'(lowGain), 0);
  endtask

  task automatic testDefaultDwell();
    int n;
    measureDwell(n);
    check("R7 reset exponent 0x0D dwell", n, 8192);
  endtask

  task automatic testImmediateLow();
    @(posedge clk); #1;
    aboveThr = 1'b1;
    #1;
    check("R1 low gain in first above cycle", int'(lowGain), 1);
    @(posedge clk); #1;
    aboveThr = 1'b0;
    repeat (4) @(posedge clk);
  endtask

  task automatic testDwell(input logic [7:0] e, input int expected, input string req);
    int n;
    writeExp(e);
    measureDwell(n);
    check(req, n, expected);
  endtask

  task automatic testRestart();
    int lowCnt = 0;
    int n;
    writeExp(8'd4);
    @(posedge clk); #1;
    aboveThr = 1'b1;
    @(posedge clk); #1;
    aboveThr = 1'b0;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (lowGain) lowCnt++;
    end
    check("R3 low gain held before re-raise", lowCnt, 10);
    measureDwell(n);
    check("R3 full dwell after restart", n, 16);
  endtask

  task automatic testStayHigh();
    int hits = 0;
    for (int i = 0; i < 50; i++) begin
      @(negedge clk);
      if (lowGain) hits++;
    end
    check("R5 high gain held while below", hits, 0);
  endtask

  initial begin
    testReset();
    testDefaultDwell();
    testImmediateLow();
    testDwell(8'd0, 1, "R2 exponent 0 dwell");
    testDwell(8'd1, 2, "R2 exponent 1 dwell");
    testDwell(8'd3, 8, "R4 written exponent 3 dwell");
    testDwell(8'd5, 32, "R2 exponent 5 dwell");
    testRestart();
    testStayHigh();
    testDwell(8'd14, 16384, "R6 exponent at limit");
    testDwell(8'd15, 16384, "R6 exponent 15 clamped");
    testDwell(8'd200, 16384, "R6 exponent 200 clamped");
    testStayHigh();
    finishRun();
  end

  initial begin
    repeat (WD_LIMIT) @(posedge clk);
    compared++;
    mismatched++;
    $display("FAIL watchdog: actual %0d cycles expected fewer", WD_LIMIT);
    finishRun();
  end

endmodule